// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers level-sensitive interrupt inputs from up to 31 sources, numbered 1 to 31 (number 0 is reserved and never used), and drives a single interrupt request line toward one processor context. Software programs it through a 32-bit register port with separate read and write strobes, an address and write data. The read data is combinational and is valid in the same cycle as the read strobe.

Each source has a three-bit priority, an enable bit and a pending bit. The context has a three-bit threshold. A source is eligible when it is pending, enabled, and its priority is strictly above the threshold. The request line shows whether any source is eligible. The handler reads the claim register to get the winning source number. That read clears the source's pending bit and places the source in service. When the handler is done, it writes the number back to the same address. This completion releases the source so that its input can make it pending again.

Register offsets: priority of source n at 4*n, the pending view at 0x1000 (read only), the enable word at 0x2000, the threshold at 0x200000, and claim/complete at 0x200004.

Top module: `intc_prio_ctrl`

## Requirements
- R1: After reset all priorities, enables, the threshold and all pending bits read as 0, the claim register reads 0, and the request line is low.
- R2: A priority write keeps only write-data bits [2:0], and reads return them zero-extended. The priority of source 0 always reads 0.
- R3: Bit n of the pending view is set on the first clock edge at which input n is high while source n is not in service. A pending bit stays set until the source is claimed. Bit 0 is always 0, and writes to the pending view have no effect.
- R4: Bit n of the enable word enables source n. Bit 0 always reads 0. A disabled source never raises the request line and is never returned by a claim.
- R5: A source with priority 0 never raises the request line and is never returned by a claim.
- R6: A source is masked when its priority is less than or equal to the threshold. A threshold write keeps only bits [2:0], so a threshold of 7 masks all sources.
- R7: A claim read returns the number of the eligible source with the highest priority. Among sources of equal priority it returns the lowest number. It returns 0 when no source is eligible.
- R8: A claim read that returns a nonzero number clears that source's pending bit at the same clock edge. The source then stays in service and does not become pending again while its input stays high.
- R9: Writing number n to claim/complete while source n is enabled ends service of source n. If input n is still high, pending bit n is set again at the next clock edge. The number written does not have to match the last number claimed.
- R10: A completion write naming a source that is currently disabled is ignored. That source stays in service.
- R11: The request line is high exactly when at least one eligible source exists. It follows the pending, enable, priority and threshold state in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe; a claim read has its side effect at the clock edge |
| busAddr | input | 22 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| srcLevel | input | 32 | Level interrupt inputs; bit n belongs to source n, and bit 0 is ignored |
| irqReq | output | 1 | Interrupt request to the context |

## Verification
Priority ties are tested with two sources at the same top level and a third source below them. A comparison that updates on greater-or-equal would return the higher number of the tied pair first. The threshold is tested at equality, where a design that compares with greater-or-equal would raise a request it should mask. The bench also holds inputs high across a claim to check that the source stays in service, and writes a completion for a source other than the last one claimed. It then writes a completion for a disabled source, which a design that skipped the enable check would wrongly release. Other cases cover a pending bit that must survive a write to the pending view, and a priority-0 source that must stay silent even though its pending bit is set.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRIO,
    RD_PEND,
    RD_EN,
    RD_THR,
    RD_CLAIM
  } rdSel_e;

  typedef struct packed {
    logic   wrPrio;
    logic   wrEnable;
    logic   wrThresh;
    logic   wrComplete;
    logic   rdClaim;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 22,
  parameter int ID_W    = 5
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strb,
  output logic [ID_W-1:0]   prioIdx
);

  localparam logic [ADDR_W-1:0] PRIO_SPAN = ADDR_W'(NUM_SRC * 4);
  localparam logic [ADDR_W-1:0] OFF_PEND  = ADDR_W'('h1000);
  localparam logic [ADDR_W-1:0] OFF_EN    = ADDR_W'('h2000);
  localparam logic [ADDR_W-1:0] OFF_THR   = ADDR_W'('h200000);
  localparam logic [ADDR_W-1:0] OFF_CLAIM = ADDR_W'('h200004);

  logic hitPrio, hitPend, hitEn, hitThr, hitClaim;

  always_comb begin
    hitPrio  = (busAddr < PRIO_SPAN) && (busAddr[1:0] == 2'b00);
    hitPend  = (busAddr == OFF_PEND);
    hitEn    = (busAddr == OFF_EN);
    hitThr   = (busAddr == OFF_THR);
    hitClaim = (busAddr == OFF_CLAIM);
  end

  always_comb begin
    strb            = '0;
    strb.rdSel      = RD_NONE;
    strb.wrPrio     = busWrEn && hitPrio;
    strb.wrEnable   = busWrEn && hitEn;
    strb.wrThresh   = busWrEn && hitThr;
    strb.wrComplete = busWrEn && hitClaim;
    strb.rdClaim    = busRdEn && hitClaim;
    if (busRdEn) begin
      if (hitPrio)       strb.rdSel = RD_PRIO;
      else if (hitPend)  strb.rdSel = RD_PEND;
      else if (hitEn)    strb.rdSel = RD_EN;
      else if (hitThr)   strb.rdSel = RD_THR;
      else if (hitClaim) strb.rdSel = RD_CLAIM;
    end
  end

  assign prioIdx = busAddr[ID_W+1:2];

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [ID_W-1:0]    prioIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] svcVec
);

  logic [PRIO_W-1:0]  prioQ [NUM_SRC];
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] eligVec;
  logic [PRIO_W-1:0]  thrQ;
  logic [ID_W-1:0]    winId;
  logic [PRIO_W-1:0]  winPrio;
  logic [ID_W-1:0]    cmplId;
  logic               cmplValid;

  assign cmplId    = wrData[ID_W-1:0];
  assign cmplValid = strb.wrComplete && (wrData[DATA_W-1:ID_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              thrQ <= '0;
    else if (strb.wrThresh) thrQ <= wrData[PRIO_W-1:0];
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    if (n == 0) begin : g_null
      assign prioQ[n]   = '0;
      assign enVec[n]   = 1'b0;
      assign pendVec[n] = 1'b0;
      assign svcVec[n]  = 1'b0;
      assign eligVec[n] = 1'b0;
    end else begin : g_live
      logic [PRIO_W-1:0] prioBit;
      logic enBit, pendBit, svcBit;
      logic claimHit, cmplHit;

      assign claimHit = strb.rdClaim && (winId == ID_W'(n));
      assign cmplHit  = cmplValid && (cmplId == ID_W'(n)) && enBit;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prioBit <= '0;
          enBit   <= 1'b0;
          pendBit <= 1'b0;
          svcBit  <= 1'b0;
        end else begin
          if (strb.wrPrio && prioIdx == ID_W'(n)) prioBit <= wrData[PRIO_W-1:0];
          if (strb.wrEnable) enBit <= wrData[n];
          if (claimHit)                       pendBit <= 1'b0;
          else if (srcLevel[n] && !svcBit)    pendBit <= 1'b1;
          if (claimHit)     svcBit <= 1'b1;
          else if (cmplHit) svcBit <= 1'b0;
        end
      end

      assign prioQ[n]   = prioBit;
      assign enVec[n]   = enBit;
      assign pendVec[n] = pendBit;
      assign svcVec[n]  = svcBit;
      assign eligVec[n] = pendBit && enBit && (prioBit > thrQ);
    end
  end

  // Strict greater-than keeps the lowest number among equal priorities.
  always_comb begin
    winId   = '0;
    winPrio = '0;
    for (int n = 1; n < NUM_SRC; n++) begin
      if (eligVec[n] && prioQ[n] > winPrio) begin
        winId   = ID_W'(n);
        winPrio = prioQ[n];
      end
    end
  end

  assign irqReq = |eligVec;

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_PRIO:  rdData = DATA_W'(prioQ[prioIdx]);
      RD_PEND:  rdData = DATA_W'(pendVec);
      RD_EN:    rdData = DATA_W'(enVec);
      RD_THR:   rdData = DATA_W'(thrQ);
      RD_CLAIM: rdData = DATA_W'(winId);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/intc_prio_ctrl.sv
module intc_prio_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               irqReq
);

  localparam int ID_W = $clog2(NUM_SRC);

  ctrlStrobes_t       strb;
  logic [ID_W-1:0]    prioIdx;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] svcVec;

  intc_control #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)
  ) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .strb(strb), .prioIdx(prioIdx)
  );

  intc_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .prioIdx(prioIdx),
    .wrData(busWrData), .srcLevel(srcLevel), .rdData(busRdData),
    .irqReq(irqReq), .pendVec(pendVec), .svcVec(svcVec)
  );

endmodule

// File: rtl/intc_prio_ctrl_chk.sv
module intc_prio_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busRdEn,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busRdData,
  input logic               irqReq,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] svcVec
);

  localparam int ID_W = $clog2(NUM_SRC);
  localparam logic [ADDR_W-1:0] CLAIM_ADDR = ADDR_W'('h200004);

  logic claimRd;
  assign claimRd = busRdEn && !busWrEn && (busAddr == CLAIM_ADDR);

  AST_REQ_MATCHES_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    claimRd |-> (irqReq == (busRdData != '0))); // R11

  AST_CLAIM_IS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && busRdData != '0) |-> pendVec[busRdData[ID_W-1:0]]); // R7

  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && busRdData != '0) |=> !pendVec[$past(busRdData[ID_W-1:0])]); // R8

  AST_SVC_NO_REPEND: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendVec & ~$past(pendVec) & $past(svcVec)) == '0)); // R8

  AST_SLOT0_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pendVec[0] && !svcVec[0]); // R3

  AST_PRIO_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr < ADDR_W'(NUM_SRC * 4) && busAddr[1:0] == 2'b00)
      |-> (busRdData[DATA_W-1:PRIO_W] == '0)); // R2

endmodule

bind intc_prio_ctrl intc_prio_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busRdEn(busRdEn), .busWrEn(busWrEn),
  .busAddr(busAddr), .busRdData(busRdData), .irqReq(irqReq),
  .pendVec(pendVec), .svcVec(svcVec)
);

// File: tb/intc_prio_ctrl_bench.sv
`timescale 1ns/1ps
module intc_prio_ctrl_bench;

  localparam logic [21:0] A_PEND  = 22'h1000;
  localparam logic [21:0] A_EN    = 22'h2000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [21:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] srcLevel = '0;
  logic        irqReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  intc_prio_ctrl u_intc_prio_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .srcLevel(srcLevel), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    busRead(A_PEND, v);  chk("R1 pend", v, 0);
    busRead(A_EN, v);    chk("R1 enable", v, 0);
    busRead(A_THR, v);   chk("R1 thresh", v, 0);
    busRead(22'h14, v);  chk("R1 prio5", v, 0);
    busRead(A_CLAIM, v); chk("R1 claim", v, 0);
    chk("R1 irq", irqReq, 0);
  endtask

  task automatic t_prio_regs;
    logic [31:0] v;
    busWrite(22'hC, 32'hFF);
    busRead(22'hC, v);  chk("R2 low bits kept", v, 7);
    busWrite(22'h0, 32'h5);
    busRead(22'h0, v);  chk("R2 slot0 prio", v, 0);
  endtask

  task automatic t_pending_disabled;
    logic [31:0] v;
    srcLevel[3] = 1'b1;
    srcLevel[0] = 1'b1;
    idle(2);
    chk("R4 disabled no irq", irqReq, 0);
    busRead(A_PEND, v); chk("R3 pend bit3 only", v, 32'h8);
    busWrite(A_PEND, 32'h0);
    busRead(A_PEND, v); chk("R3 pend write ignored", v, 32'h8);
    busRead(A_CLAIM, v); chk("R4 disabled not claimed", v, 0);
    srcLevel[0] = 1'b0;
  endtask

  task automatic t_enable_claim;
    logic [31:0] v;
    busWrite(A_EN, 32'hFFFF_FFFF);
    busRead(A_EN, v); chk("R4 enable bit0 zero", v, 32'hFFFF_FFFE);
    idle(1);
    chk("R11 irq eligible", irqReq, 1);
    busRead(A_CLAIM, v); chk("R7 claim id", v, 3);
    idle(1);
    chk("R11 irq after claim", irqReq, 0);
    idle(3);
    busRead(A_PEND, v); chk("R8 held in service", v & 32'h8, 0);
    busWrite(A_CLAIM, 32'd3);
    busRead(A_PEND, v); chk("R9 repend after complete", v & 32'h8, 32'h8);
    busRead(A_CLAIM, v); chk("R8 second claim", v, 3);
    srcLevel[3] = 1'b0;
    busWrite(A_CLAIM, 32'd3);
    idle(2);
    busRead(A_PEND, v); chk("R9 no repend when low", v & 32'h8, 0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    busWrite(22'd5 * 4, 32'd2);
    busWrite(22'd9 * 4, 32'd6);
    busWrite(22'd12 * 4, 32'd6);
    srcLevel[5] = 1'b1; srcLevel[9] = 1'b1; srcLevel[12] = 1'b1;
    idle(2);
    busRead(A_CLAIM, v); chk("R7 tie lowest id", v, 9);
    busRead(A_CLAIM, v); chk("R7 next tied", v, 12);
    busRead(A_CLAIM, v); chk("R7 lower prio", v, 5);
    busRead(A_CLAIM, v); chk("R7 none left", v, 0);
    srcLevel[5] = 1'b0; srcLevel[9] = 1'b0; srcLevel[12] = 1'b0;
    busWrite(A_CLAIM, 32'd9);
    busWrite(A_CLAIM, 32'd12);
    busWrite(A_CLAIM, 32'd5);
  endtask

  task automatic t_zero_prio;
    logic [31:0] v;
    srcLevel[7] = 1'b1;
    idle(2);
    busRead(A_PEND, v); chk("R5 pending set", v & 32'h80, 32'h80);
    chk("R5 no irq", irqReq, 0);
    busRead(A_CLAIM, v); chk("R5 not claimed", v, 0);
    srcLevel[7] = 1'b0;
  endtask

  task automatic t_threshold;
    logic [31:0] v;
    busWrite(22'd4 * 4, 32'd3);
    busWrite(A_THR, 32'd3);
    srcLevel[4] = 1'b1;
    idle(2);
    chk("R6 equal masked", irqReq, 0);
    busRead(A_CLAIM, v); chk("R6 equal not claimed", v, 0);
    busWrite(A_THR, 32'd2);
    idle(1);
    chk("R6 above passes", irqReq, 1);
    busWrite(A_THR, 32'hF);
    busRead(A_THR, v); chk("R6 thresh low bits", v, 7);
    idle(1);
    chk("R6 thresh 7 masks", irqReq, 0);
    busWrite(A_THR, 32'd0);
    busRead(A_CLAIM, v); chk("R7 claim after unmask", v, 4);
    srcLevel[4] = 1'b0;
    busWrite(A_CLAIM, 32'd4);
  endtask

  task automatic t_complete_rules;
    logic [31:0] v;
    busWrite(22'd10 * 4, 32'd4);
    busWrite(22'd11 * 4, 32'd4);
    srcLevel[10] = 1'b1; srcLevel[11] = 1'b1;
    idle(2);
    busRead(A_CLAIM, v); chk("R7 claim 10", v, 10);
    busRead(A_CLAIM, v); chk("R7 claim 11", v, 11);
    busWrite(A_CLAIM, 32'd10);
    busRead(A_PEND, v); chk("R9 unmatched id accepted", v & 32'hC00, 32'h400);
    busWrite(A_EN, 32'hFFFF_F7FF);
    busWrite(A_CLAIM, 32'd11);
    idle(2);
    busWrite(A_EN, 32'hFFFF_FFFF);
    idle(2);
    busRead(A_PEND, v); chk("R10 disabled completion ignored", v & 32'h800, 0);
    chk("R11 irq from 10 only", irqReq, 1);
    busWrite(A_CLAIM, 32'd11);
    busRead(A_PEND, v); chk("R9 repend 11", v & 32'h800, 32'h800);
    busRead(A_CLAIM, v); chk("R7 claim 10 again", v, 10);
    busRead(A_CLAIM, v); chk("R7 claim 11 again", v, 11);
    srcLevel[10] = 1'b0; srcLevel[11] = 1'b0;
    busWrite(A_CLAIM, 32'd10);
    busWrite(A_CLAIM, 32'd11);
    idle(2);
    chk("R11 quiet at end", irqReq, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_prio_regs();
    t_pending_disabled();
    t_enable_claim();
    t_order();
    t_zero_prio();
    t_threshold();
    t_complete_rules();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

endmodule